// File: doc/BRIEF.md
# Event Counter Unit

This block gives a cluster of on-chip logic a set of memory-mapped event counters. A bus of single-cycle event strobes comes in, one bit per event code. Each counter selects one strobe with an 8-bit code and advances by one on every cycle in which that strobe is high. It only advances while both the shared count enable and its own enable are set.

When a counter rolls past its largest value it latches a pending bit. Unmasked pending bits drive a single interrupt line. Software clears a pending bit by writing a 1 to its position in a separate clear register. A counter can be loaded through the register port, so software can preload a period and be interrupted when that period has elapsed.

A two-bit channel filter narrows a fixed range of event codes to traffic from one ring channel. The filter compares against a channel tag that arrives alongside the strobes. Two further trace-tag registers only store their fields for logic outside this block.

Top module: `evctr_unit`

## Requirements
- R1: After reset, the interrupt mask at offset 0x0800 reads as all ones (0xFF for eight counters). The control register, the status register, the select registers, the trace-tag registers and all counters read as zero, and `irq` is low.
- R2: Counter n occupies offset 0x1E00 + 8·n (low 32 bits) and 0x1E00 + 8·n + 4 (high 32 bits). Each half can be written and read back independently. A write to a half replaces that half and blocks counting in the same cycle.
- R3: Event codes are 8 bits wide, four per select register, at offset 0x1D00 + 4·m. Counter n takes bits [8·(n mod 4)+7 : 8·(n mod 4)] of select register n/4. Counter n counts `ev_strobe[code]`.
- R4: The control register is at offset 0x1C00, with bit 26 as the shared enable and bit n as the enable of counter n. A counter gains exactly one per clock edge on which both enables are set and its selected strobe is high. Otherwise it does not change.
- R5: While bit 26 is clear, no counter changes, whatever its own enable and its strobe are.
- R6: Control bits 28:27 hold a channel filter, and 0 means no filtering. When the filter is nonzero, a counter whose code lies in 0x47..0x59 counts only in cycles where `ev_chan` equals the filter. Codes outside that range ignore the filter.
- R7: When a counter steps from all ones to zero, status bit n (offset 0x0808) is set. The counter continues from zero. The status register ignores writes.
- R8: `irq` is high exactly when some status bit is set and the matching mask bit (offset 0x0800, 1 = masked) is clear.
- R9: Writing to offset 0x080C clears each status bit whose data bit is 1, and leaves the others unchanged. If the same counter rolls over in the same cycle, its status bit remains set.
- R10: Offset 0x1CF0 returns the parameter `VERSION_ID` and ignores writes.
- R11: The trace-tag register at 0x1B2C keeps only bits 9:7, 3, 2 and 0. The source-ID register at 0x1B40 keeps only bits 14:1. The control register keeps only bits 29:26 and its counter-enable bits. All other bits read zero.
- R12: A read request produces `rd_valid` high one cycle later, with `rd_data` holding the register value. Unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Register access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (16) | Byte offset of the register |
| req_wdata | input | DATA_W (32) | Write data |
| rd_valid | output | 1 | Read data valid (one cycle after a read) |
| rd_data | output | DATA_W (32) | Read data |
| ev_strobe | input | 2**CODE_W (256) | One strobe per event code |
| ev_chan | input | CHAN_W (2) | Ring channel tag of the current event traffic |
| irq | output | 1 | Any unmasked pending rollover |

## Verification
The hardest case to reach from the ports is a clear write that lands on the exact clock edge at which the same counter rolls over. The stimulus builds this case in steps. With counting disabled, it preloads the counter to two below its wrap point and holds the selected strobe high. It then enables counting with one write and issues the clear write two edges later. The rollover falls on the same edge as the clear, and the pending bit must survive it. The channel filter is exercised with one code inside and one code outside the filtered range, counting side by side under a matching channel tag and a mismatching one.

// File: rtl/evctr_pkg.sv
// Shared offsets and field positions of the event counter unit.
// Assumes a 16-bit byte offset space and 32-bit register words.
package evctr_pkg;
    localparam logic [15:0] OFS_IMASK    = 16'h0800;
    localparam logic [15:0] OFS_ISTAT    = 16'h0808;
    localparam logic [15:0] OFS_ICLR     = 16'h080C;
    localparam logic [15:0] OFS_TAGCTL   = 16'h1B2C;
    localparam logic [15:0] OFS_SRCID    = 16'h1B40;
    localparam logic [15:0] OFS_CTRL     = 16'h1C00;
    localparam logic [15:0] OFS_VER      = 16'h1CF0;
    localparam logic [15:0] OFS_SEL_BASE = 16'h1D00;
    localparam logic [15:0] OFS_CNT_BASE = 16'h1E00;

    localparam int unsigned CTRL_GLB_BIT = 26;
    localparam int unsigned CTRL_CHAN_LO = 27;
    localparam int unsigned CTRL_TAG_BIT = 29;

    localparam logic [31:0] TAGCTL_KEEP = 32'h0000_038D;
    localparam logic [31:0] SRCID_KEEP  = 32'h0000_7FFE;

    localparam logic [7:0] CHFILT_LO = 8'h47;
    localparam logic [7:0] CHFILT_HI = 8'h59;
endpackage

// File: rtl/evctr_regs.sv
// Configuration registers: control word, event select words, interrupt
// mask and the two trace-tag words. Writes take effect on the next edge.
// Assumes DATA_W is a multiple of CODE_W and NUM_CTR <= 26.
module evctr_regs
    import evctr_pkg::*;
#(
    parameter int NUM_CTR = 8,
    parameter int CODE_W  = 8,
    parameter int CHAN_W  = 2,
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 32,
    parameter int NUM_SEL = (NUM_CTR * CODE_W + DATA_W - 1) / DATA_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [DATA_W-1:0]           wr_data,
    output logic                        glb_en,
    output logic [NUM_CTR-1:0]          ctr_en,
    output logic [CHAN_W-1:0]           chan_filter,
    output logic [NUM_CTR-1:0]          int_mask,
    output logic [NUM_CTR*CODE_W-1:0]   code_flat,
    output logic [DATA_W-1:0]           ctrl_word,
    output logic [DATA_W-1:0]           tagctl_word,
    output logic [DATA_W-1:0]           srcid_word,
    output logic [NUM_SEL*DATA_W-1:0]   sel_flat
);
    localparam int CPR = DATA_W / CODE_W;

    logic              tag_en;
    logic [DATA_W-1:0] sel_q [NUM_SEL];

    // Control, mask and trace-tag storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glb_en      <= 1'b0;
            ctr_en      <= '0;
            chan_filter <= '0;
            tag_en      <= 1'b0;
            int_mask    <= '1;
            tagctl_word <= '0;
            srcid_word  <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_W'(OFS_CTRL)) begin
                glb_en      <= wr_data[CTRL_GLB_BIT];
                ctr_en      <= wr_data[NUM_CTR-1:0];
                chan_filter <= wr_data[CTRL_CHAN_LO +: CHAN_W];
                tag_en      <= wr_data[CTRL_TAG_BIT];
            end
            if (wr_addr == ADDR_W'(OFS_IMASK))
                int_mask <= wr_data[NUM_CTR-1:0];
            if (wr_addr == ADDR_W'(OFS_TAGCTL))
                tagctl_word <= wr_data & DATA_W'(TAGCTL_KEEP);
            if (wr_addr == ADDR_W'(OFS_SRCID))
                srcid_word <= wr_data & DATA_W'(SRCID_KEEP);
        end
    end

    // Event select words, one register each.
    for (genvar m = 0; m < NUM_SEL; m++) begin : g_sel
        always_ff @(posedge clk) begin
            if (!rst_n)
                sel_q[m] <= '0;
            else if (wr_en && wr_addr == ADDR_W'(int'(OFS_SEL_BASE) + 4 * m))
                sel_q[m] <= wr_data;
        end
        assign sel_flat[m*DATA_W +: DATA_W] = sel_q[m];
    end

    // Each counter's code is its own byte lane of its select word.
    for (genvar n = 0; n < NUM_CTR; n++) begin : g_code
        assign code_flat[n*CODE_W +: CODE_W] = sel_q[n / CPR][(n % CPR) * CODE_W +: CODE_W];
    end

    // Readback image of the control register.
    always_comb begin
        ctrl_word                             = '0;
        ctrl_word[NUM_CTR-1:0]                = ctr_en;
        ctrl_word[CTRL_GLB_BIT]               = glb_en;
        ctrl_word[CTRL_CHAN_LO +: CHAN_W]     = chan_filter;
        ctrl_word[CTRL_TAG_BIT]               = tag_en;
    end
endmodule

// File: rtl/evctr_counter.sv
// One event counter: picks a strobe by code, applies the channel qualifier
// and counts. Software writes to either half win over counting.
// Assumes CTR_W == 2 * DATA_W and 2**CODE_W strobes.
module evctr_counter
    import evctr_pkg::*;
#(
    parameter int CTR_W  = 64,
    parameter int CODE_W = 8,
    parameter int CHAN_W = 2,
    parameter int DATA_W = 32,
    parameter int NUM_EV = 2 ** CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              count_en,
    input  logic [CODE_W-1:0] code,
    input  logic [NUM_EV-1:0] ev_strobe,
    input  logic [CHAN_W-1:0] chan_filter,
    input  logic [CHAN_W-1:0] ev_chan,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wdata,
    output logic [CTR_W-1:0]  value,
    output logic              ovf
);
    logic in_range;
    logic chan_ok;
    logic hit;

    // Strobe selection and channel qualifier.
    always_comb begin
        in_range = (CODE_W'(CHFILT_LO) <= code) && (code <= CODE_W'(CHFILT_HI));
        chan_ok  = (chan_filter == '0) || !in_range || (ev_chan == chan_filter);
        hit      = count_en && ev_strobe[code] && chan_ok;
        ovf      = hit && !wr_lo && !wr_hi && (&value);
    end

    // Counter state: software load first, then counting.
    always_ff @(posedge clk) begin
        if (!rst_n)
            value <= '0;
        else if (wr_lo || wr_hi) begin
            if (wr_lo) value[DATA_W-1:0]     <= wdata;
            if (wr_hi) value[CTR_W-1:DATA_W] <= wdata;
        end else if (hit)
            value <= value + CTR_W'(1);
    end
endmodule

// File: rtl/evctr_irq.sv
// Pending-rollover status with write-1-clear and a masked interrupt line.
// A rollover in the same cycle as its clear keeps the bit set.
module evctr_irq #(
    parameter int NUM_CTR = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CTR-1:0] ovf,
    input  logic [NUM_CTR-1:0] mask,
    input  logic               clr_wr,
    input  logic [NUM_CTR-1:0] clr_bits,
    output logic [NUM_CTR-1:0] status,
    output logic               irq
);
    // Status update: clear first, new rollovers override.
    always_ff @(posedge clk) begin
        if (!rst_n)
            status <= '0;
        else
            status <= (status & ~(clr_wr ? clr_bits : '0)) | ovf;
    end

    // Interrupt line from unmasked pending bits.
    always_comb irq = |(status & ~mask);
endmodule

// File: rtl/evctr_unit.sv
// Top of the event counter unit: register port decode, counter array,
// interrupt logic and a registered read path (one cycle latency).
// Assumes a single requester and 32-bit aligned offsets.
module evctr_unit
    import evctr_pkg::*;
#(
    parameter int          NUM_CTR    = 8,
    parameter int          CTR_W      = 64,
    parameter int          CODE_W     = 8,
    parameter int          CHAN_W     = 2,
    parameter int          ADDR_W     = 16,
    parameter int          DATA_W     = 32,
    parameter logic [31:0] VERSION_ID = 32'h0102_0300
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [DATA_W-1:0]      req_wdata,
    output logic                   rd_valid,
    output logic [DATA_W-1:0]      rd_data,
    input  logic [2**CODE_W-1:0]   ev_strobe,
    input  logic [CHAN_W-1:0]      ev_chan,
    output logic                   irq
);
    localparam int NUM_EV  = 2 ** CODE_W;
    localparam int NUM_SEL = (NUM_CTR * CODE_W + DATA_W - 1) / DATA_W;

    logic                        wr_en;
    logic                        glb_en;
    logic [NUM_CTR-1:0]          ctr_en;
    logic [CHAN_W-1:0]           chan_filter;
    logic [NUM_CTR-1:0]          int_mask;
    logic [NUM_CTR*CODE_W-1:0]   code_flat;
    logic [DATA_W-1:0]           ctrl_word;
    logic [DATA_W-1:0]           tagctl_word;
    logic [DATA_W-1:0]           srcid_word;
    logic [NUM_SEL*DATA_W-1:0]   sel_flat;
    logic [NUM_CTR*CTR_W-1:0]    cnt_flat;
    logic [NUM_CTR-1:0]          ovf_vec;
    logic [NUM_CTR-1:0]          cnt_wr;
    logic [NUM_CTR-1:0]          status;
    logic                        clr_wr;
    logic [DATA_W-1:0]           rd_next;

    assign wr_en  = req_valid && req_write;
    assign clr_wr = wr_en && (req_addr == ADDR_W'(OFS_ICLR));

    evctr_regs #(
        .NUM_CTR (NUM_CTR),
        .CODE_W  (CODE_W),
        .CHAN_W  (CHAN_W),
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .NUM_SEL (NUM_SEL)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (req_addr),
        .wr_data     (req_wdata),
        .glb_en      (glb_en),
        .ctr_en      (ctr_en),
        .chan_filter (chan_filter),
        .int_mask    (int_mask),
        .code_flat   (code_flat),
        .ctrl_word   (ctrl_word),
        .tagctl_word (tagctl_word),
        .srcid_word  (srcid_word),
        .sel_flat    (sel_flat)
    );

    for (genvar n = 0; n < NUM_CTR; n++) begin : g_ctr
        logic wr_lo;
        logic wr_hi;
        assign wr_lo     = wr_en && (req_addr == ADDR_W'(int'(OFS_CNT_BASE) + 8 * n));
        assign wr_hi     = wr_en && (req_addr == ADDR_W'(int'(OFS_CNT_BASE) + 8 * n + 4));
        assign cnt_wr[n] = wr_lo || wr_hi;

        evctr_counter #(
            .CTR_W  (CTR_W),
            .CODE_W (CODE_W),
            .CHAN_W (CHAN_W),
            .DATA_W (DATA_W),
            .NUM_EV (NUM_EV)
        ) u_cnt (
            .clk         (clk),
            .rst_n       (rst_n),
            .count_en    (glb_en && ctr_en[n]),
            .code        (code_flat[n*CODE_W +: CODE_W]),
            .ev_strobe   (ev_strobe),
            .chan_filter (chan_filter),
            .ev_chan     (ev_chan),
            .wr_lo       (wr_lo),
            .wr_hi       (wr_hi),
            .wdata       (req_wdata),
            .value       (cnt_flat[n*CTR_W +: CTR_W]),
            .ovf         (ovf_vec[n])
        );
    end

    evctr_irq #(
        .NUM_CTR (NUM_CTR)
    ) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .ovf      (ovf_vec),
        .mask     (int_mask),
        .clr_wr   (clr_wr),
        .clr_bits (req_wdata[NUM_CTR-1:0]),
        .status   (status),
        .irq      (irq)
    );

    // Read multiplexer over every mapped offset.
    always_comb begin
        rd_next = '0;
        if (req_addr == ADDR_W'(OFS_CTRL))   rd_next = ctrl_word;
        if (req_addr == ADDR_W'(OFS_IMASK))  rd_next = DATA_W'(int_mask);
        if (req_addr == ADDR_W'(OFS_ISTAT))  rd_next = DATA_W'(status);
        if (req_addr == ADDR_W'(OFS_VER))    rd_next = DATA_W'(VERSION_ID);
        if (req_addr == ADDR_W'(OFS_TAGCTL)) rd_next = tagctl_word;
        if (req_addr == ADDR_W'(OFS_SRCID))  rd_next = srcid_word;
        for (int m = 0; m < NUM_SEL; m++)
            if (req_addr == ADDR_W'(int'(OFS_SEL_BASE) + 4 * m))
                rd_next = sel_flat[m*DATA_W +: DATA_W];
        for (int n = 0; n < NUM_CTR; n++) begin
            if (req_addr == ADDR_W'(int'(OFS_CNT_BASE) + 8 * n))
                rd_next = cnt_flat[n*CTR_W +: DATA_W];
            if (req_addr == ADDR_W'(int'(OFS_CNT_BASE) + 8 * n + 4))
                rd_next = cnt_flat[n*CTR_W + DATA_W +: DATA_W];
        end
    end

    // Registered read response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= req_valid && !req_write;
            rd_data  <= (req_valid && !req_write) ? rd_next : '0;
        end
    end
endmodule

// File: rtl/evctr_chk.sv
// Property checker for the event counter unit, attached by bind.
module evctr_chk #(
    parameter int          NUM_CTR    = 8,
    parameter int          CTR_W      = 64,
    parameter int          ADDR_W     = 16,
    parameter int          DATA_W     = 32,
    parameter logic [31:0] VERSION_ID = 32'h0
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     glb_en,
    input logic [NUM_CTR-1:0]       cnt_wr,
    input logic [NUM_CTR*CTR_W-1:0] cnt_flat,
    input logic [NUM_CTR-1:0]       ovf_vec,
    input logic [NUM_CTR-1:0]       status,
    input logic [NUM_CTR-1:0]       int_mask,
    input logic                     clr_wr,
    input logic                     irq,
    input logic                     req_valid,
    input logic                     req_write,
    input logic [ADDR_W-1:0]        req_addr,
    input logic                     rd_valid,
    input logic [DATA_W-1:0]        rd_data
);
    for (genvar n = 0; n < NUM_CTR; n++) begin : g_prop
        AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
            (!glb_en && !cnt_wr[n]) |=> $stable(cnt_flat[n*CTR_W +: CTR_W])); // R5
        AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
            !cnt_wr[n] |=> (cnt_flat[n*CTR_W +: CTR_W] == $past(cnt_flat[n*CTR_W +: CTR_W]))
                        || (cnt_flat[n*CTR_W +: CTR_W] == $past(cnt_flat[n*CTR_W +: CTR_W]) + CTR_W'(1))); // R4
    end

    AST_OVF_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_vec != '0) |=> ((status & $past(ovf_vec)) == $past(ovf_vec))); // R9

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_wr |=> ((status & $past(status)) == $past(status))); // R7

    AST_ALL_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (int_mask == '1) |-> !irq); // R8

    AST_VERSION_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr == ADDR_W'(16'h1CF0))
            |=> (rd_valid && rd_data == DATA_W'(VERSION_ID))); // R10
endmodule

bind evctr_unit evctr_chk #(
    .NUM_CTR    (NUM_CTR),
    .CTR_W      (CTR_W),
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .VERSION_ID (VERSION_ID)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .glb_en    (glb_en),
    .cnt_wr    (cnt_wr),
    .cnt_flat  (cnt_flat),
    .ovf_vec   (ovf_vec),
    .status    (status),
    .int_mask  (int_mask),
    .clr_wr    (clr_wr),
    .irq       (irq),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
);

// File: tb/test_evctr_unit.sv
`timescale 1ns/1ps
module test_evctr_unit;
    localparam logic [31:0] VER = 32'h0102_0300;
    localparam logic [15:0] A_MASK = 16'h0800, A_STAT = 16'h0808, A_CLR = 16'h080C;
    localparam logic [15:0] A_TAG = 16'h1B2C, A_SRC = 16'h1B40, A_CTRL = 16'h1C00;
    localparam logic [15:0] A_VER = 16'h1CF0, A_SEL = 16'h1D00, A_CNT = 16'h1E00;
    localparam logic [31:0] GLB = 32'h0400_0000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_write = 1'b0;
    logic [15:0]  req_addr = '0;
    logic [31:0]  req_wdata = '0;
    logic         rd_valid;
    logic [31:0]  rd_data;
    logic [255:0] ev_strobe = '0;
    logic [1:0]   ev_chan = '0;
    logic         irq;
    int           checks = 0;
    int           errors = 0;

    always #2.5 clk = ~clk;

    evctr_unit #(.VERSION_ID(VER)) i_evctr_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid),
        .rd_data(rd_data), .ev_strobe(ev_strobe), .ev_chan(ev_chan), .irq(irq)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        d = rd_data;
        check("R12 rd_valid", 64'(rd_valid), 64'd1);
        req_valid = 1'b0;
    endtask

    task automatic rd_cnt(input int n, output logic [63:0] v);
        logic [31:0] lo, hi;
        rd(A_CNT + 16'(8 * n), lo);
        rd(A_CNT + 16'(8 * n + 4), hi);
        v = {hi, lo};
    endtask

    task automatic pulse(input int code, input int cycles);
        ev_strobe[code] = 1'b1;
        repeat (cycles) @(negedge clk);
        ev_strobe[code] = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        logic [63:0] v;
        rd(A_MASK, d); check("R1 mask reset", 64'(d), 64'hFF);
        rd(A_CTRL, d); check("R1 ctrl reset", 64'(d), 64'h0);
        rd(A_STAT, d); check("R1 status reset", 64'(d), 64'h0);
        rd(A_SEL, d);  check("R1 select reset", 64'(d), 64'h0);
        rd_cnt(7, v);  check("R1 counter reset", v, 64'h0);
        check("R1 irq reset", 64'(irq), 64'h0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        rd(A_VER, d); check("R10 version", 64'(d), 64'(VER));
        wr(A_VER, 32'h0);
        rd(A_VER, d); check("R10 version ignores write", 64'(d), 64'(VER));
        wr(A_TAG, 32'hFFFF_FFFF);
        rd(A_TAG, d); check("R11 trace-tag bits", 64'(d), 64'h38D);
        wr(A_SRC, 32'hFFFF_FFFF);
        rd(A_SRC, d); check("R11 source-id bits", 64'(d), 64'h7FFE);
        wr(A_CTRL, 32'hFFFF_FFFF);
        rd(A_CTRL, d); check("R11 control bits", 64'(d), 64'h3C00_00FF);
        wr(A_CTRL, 32'h0);
        rd(16'h0100, d); check("R12 unmapped reads zero", 64'(d), 64'h0);
        @(negedge clk);
        check("R12 rd_valid idle", 64'(rd_valid), 64'h0);
        wr(A_STAT, 32'hFF);
        rd(A_STAT, d); check("R7 status ignores write", 64'(d), 64'h0);
    endtask

    task automatic t_count();
        logic [31:0] d;
        logic [63:0] v;
        wr(A_SEL, 32'h1312_1110);
        wr(A_SEL + 16'd4, 32'h5050_1615);
        rd(A_SEL + 16'd4, d); check("R3 select readback", 64'(d), 64'h5050_1615);
        wr(A_CTRL, GLB | 32'hFF);
        pulse(8'h11, 5);
        rd_cnt(1, v); check("R3 ctr1 byte1 code", v, 64'd5);
        rd_cnt(0, v); check("R3 ctr0 untouched", v, 64'd0);
        wr(A_CTRL, GLB | 32'h01);
        ev_strobe[8'h13] = 1'b1;
        pulse(8'h10, 3);
        ev_strobe[8'h13] = 1'b0;
        rd_cnt(0, v); check("R4 ctr0 counts", v, 64'd3);
        rd_cnt(3, v); check("R4 own enable off", v, 64'd0);
        wr(A_CTRL, 32'hFF);
        pulse(8'h12, 4);
        rd_cnt(2, v); check("R5 global off holds", v, 64'd0);
        rd_cnt(1, v); check("R5 ctr1 held", v, 64'd5);
    endtask

    task automatic t_channel();
        logic [63:0] v;
        wr(A_CTRL, GLB | 32'h50 | (32'd2 << 27));
        ev_chan = 2'd1;
        ev_strobe[8'h15] = 1'b1;
        pulse(8'h50, 3);
        ev_chan = 2'd2;
        pulse(8'h50, 2);
        ev_strobe[8'h15] = 1'b0;
        rd_cnt(6, v); check("R6 filtered code", v, 64'd2);
        rd_cnt(4, v); check("R6 code outside range", v, 64'd5);
        wr(A_CTRL, GLB | 32'h40);
        ev_chan = 2'd1;
        pulse(8'h50, 2);
        rd_cnt(6, v); check("R6 filter zero passes", v, 64'd4);
        wr(A_CTRL, 32'h0);
    endtask

    task automatic t_preload_wrap();
        logic [31:0] d;
        logic [63:0] v;
        wr(A_CNT + 16'd40, 32'h1234_5678);
        wr(A_CNT + 16'd44, 32'h9ABC_DEF0);
        rd_cnt(5, v); check("R2 preload halves", v, 64'h9ABC_DEF0_1234_5678);
        wr(A_CNT + 16'd24, 32'hFFFF_FFFF);
        wr(A_CNT + 16'd28, 32'hFFFF_FFFF);
        wr(A_CTRL, GLB | 32'h08);
        pulse(8'h13, 1);
        rd_cnt(3, v); check("R7 wrap to zero", v, 64'd0);
        rd(A_STAT, d); check("R7 status bit3", 64'(d), 64'h08);
        check("R8 masked irq low", 64'(irq), 64'd0);
        wr(A_MASK, 32'hF7);
        @(negedge clk);
        check("R8 unmasked irq high", 64'(irq), 64'd1);
        wr(A_CLR, 32'h08);
        rd(A_STAT, d); check("R9 clear bit3", 64'(d), 64'h0);
        check("R8 irq low after clear", 64'(irq), 64'd0);
        wr(A_CTRL, 32'h0);
    endtask

    task automatic t_coincide();
        logic [31:0] d;
        logic [63:0] v;
        ev_strobe[8'h10] = 1'b1;
        wr(A_CNT + 16'd0, 32'hFFFF_FFFE);
        wr(A_CNT + 16'd4, 32'hFFFF_FFFF);
        rd_cnt(0, v); check("R5 preload held while off", v, 64'hFFFF_FFFF_FFFF_FFFE);
        wr(A_CTRL, GLB | 32'h01);
        wr(A_CLR, 32'h01);
        wr(A_CTRL, 32'h0);
        ev_strobe[8'h10] = 1'b0;
        rd(A_STAT, d); check("R9 overflow beats clear", 64'(d), 64'h01);
        rd_cnt(0, v); check("R7 continues after wrap", v, 64'd2);
        wr(A_CLR, 32'h01);
        rd(A_STAT, d); check("R9 plain clear", 64'(d), 64'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_count();
        t_channel();
        t_preload_wrap();
        t_coincide();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule